// File: doc/BRIEF.md
# Parallel Flash Bus Write Front End

This block sits behind the asynchronous control pins of a byte-wide flash array. It samples chip-select, output-gate and write-strobe, all active low, on a fast system clock. A well-formed write strobe becomes a single-cycle write event that carries an address and a data byte. Two strobe lines are combined: the array sees a write strobe only while both chip-select and write-strobe are low. The address is captured when that combined strobe begins, which is the later of the two falling edges. The data is captured from the last sample before the strobe ends, which is the earlier of the two rising edges.

Several rules suppress writes:
- a strobe that is too short;
- the output gate being low at any sample during the strobe;
- a strobe that starts too soon after the previous one ended;
- a startup lockout, timed from the rise of a digital power-good input.

The block also produces the read-active and output-driver enables for the read data path. Control pins and buses all pass through two flop stages before any decision, so results appear with a fixed latency of a few clocks.

Top module: `pfw_frontend`

## Requirements
- R1: After reset `wr_valid`, `rd_active` and `dout_en` are all 0.
- R2: With chip-select low, output gate high and the lockout expired, a combined strobe held for at least MIN_LOW clock samples produces exactly one `wr_valid` pulse, one clock wide.
- R3: A combined strobe held for fewer than MIN_LOW samples produces no `wr_valid`.
- R4: If the output gate pin is low at any sample of the strobe, the write is dropped.
- R5: While chip-select is high, no write is produced and both `rd_active` and `dout_en` stay 0, whatever the other pins do.
- R6: While power-good is low, and for STARTUP_CYC clocks after its synchronised rise, every write is dropped. A write issued after that is accepted.
- R7: `wr_addr` reports the address sampled in the first sample of the combined strobe. For a strobe whose chip-select falls after write-strobe, this is the address present when chip-select falls.
- R8: `wr_data` reports the data sampled in the last sample of the combined strobe. Data changes made after the first of the two pins has risen are not taken.
- R9: A strobe that begins fewer than MIN_HIGH samples after the previous strobe ended is ignored entirely. One that begins at least MIN_HIGH samples later is accepted.
- R10: `rd_active` is 1 exactly when chip-select and output gate were both low; `dout_en` additionally needs write-strobe high. Both follow the pins three clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_good | input | 1 | Digital supply-good indication |
| ce_n_pin | input | 1 | Chip-select pin, active low |
| oe_n_pin | input | 1 | Output gate pin, active low |
| we_n_pin | input | 1 | Write-strobe pin, active low |
| addr_pin | input | AW | Address bus |
| data_pin | input | DW | Incoming data bus |
| wr_valid | output | 1 | One-cycle accepted write event |
| wr_addr | output | AW | Address of the accepted write |
| wr_data | output | DW | Data of the accepted write |
| rd_active | output | 1 | Read cycle in progress |
| dout_en | output | 1 | Drive the data pins (otherwise high impedance) |

## Verification
Two things can land in the same clock: the start of a new strobe and the moment the high-time counter from the previous strobe reaches its limit. The bench provokes this by sweeping the gap between two back-to-back strobes across MIN_HIGH-1 and MIN_HIGH. It judges each gap by counting write events, expecting one extra event exactly when the gap reaches the limit. The pulse-length sweep treats the strobe end and the low-count threshold the same way. Lockout expiry is probed by writes issued before and after it.

// File: rtl/pfw_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the flash bus write front end.
// Assumes all control pins are active low.
package pfw_pkg;
    // Synchronised view of the control pins plus the power indication.
    typedef struct packed {
        logic ce_n;
        logic oe_n;
        logic we_n;
        logic pwr_ok;
    } pin_ctrl_t;

    localparam int CTRL_W = $bits(pin_ctrl_t);
    // Idle pin levels: selects and strobe high, power not yet good.
    localparam logic [CTRL_W-1:0] CTRL_IDLE = {1'b1, 1'b1, 1'b1, 1'b0};
endpackage

// File: rtl/pfw_sync.sv
`timescale 1ns/1ps
// Module: pfw_sync
// Two-stage flop chain per bit. Used as a metastability guard for
// control pins and as an alignment delay for the buses.
// Assumes the bus is stable around the strobe edges, so the bus
// stages only align it with the control stages.
module pfw_sync #(
    parameter int              W       = 1,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] d_out
);
    genvar gi;
    generate
        for (gi = 0; gi < W; gi++) begin : g_bit
            logic st1;
            logic st2;
            // Two flops per bit, reset to the bit's idle level.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    st1 <= RST_VAL[gi];
                    st2 <= RST_VAL[gi];
                end else begin
                    st1 <= d_in[gi];
                    st2 <= st1;
                end
            end
            assign d_out[gi] = st2;
        end
    endgenerate
endmodule

// File: rtl/pfw_lockout.sv
`timescale 1ns/1ps
// Module: pfw_lockout
// Holds writes off while power is not good, and for STARTUP_CYC clocks
// after the synchronised power-good rises.
// Assumes STARTUP_CYC >= 1.
module pfw_lockout #(
    parameter int STARTUP_CYC = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_ok_s,
    output logic locked
);
    localparam int CW = $clog2(STARTUP_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(STARTUP_CYC);

    logic [CW-1:0] up_cnt;

    // Count good-power clocks and saturate at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_ok_s) begin
            up_cnt <= '0;
        end else if (up_cnt != LIMIT) begin
            up_cnt <= up_cnt + 1'b1;
        end
    end

    assign locked = (up_cnt != LIMIT);
endmodule

// File: rtl/pfw_write_qual.sv
`timescale 1ns/1ps
// Module: pfw_write_qual
// Qualifies the combined write strobe. It captures the address on the
// strobe's first sample and the data on its last sample, checks the low
// length, the high gap, the output gate and the lockout, and emits a
// one-cycle write event.
// Assumes its inputs come from the synchroniser stages.
module pfw_write_qual #(
    parameter int AW       = 18,
    parameter int DW       = 8,
    parameter int MIN_LOW  = 2,
    parameter int MIN_HIGH = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          strobe,
    input  logic          oe_high,
    input  logic          locked,
    input  logic [AW-1:0] addr_s,
    input  logic [DW-1:0] data_s,
    output logic          wr_valid,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);
    localparam int LW = $clog2(MIN_LOW + 2);
    localparam int HW = $clog2(MIN_HIGH + 2);
    localparam logic [LW-1:0] LOW_LIM  = LW'(MIN_LOW);
    localparam logic [HW-1:0] HIGH_LIM = HW'(MIN_HIGH);

    logic          strobe_d;
    logic          st_begin;
    logic          st_end;
    logic          pulse_ok;
    logic [LW-1:0] low_cnt;
    logic [HW-1:0] high_cnt;
    logic [AW-1:0] addr_cap;
    logic [DW-1:0] data_cap;
    logic          fire;

    assign st_begin = strobe && !strobe_d;
    assign st_end   = !strobe && strobe_d;
    assign fire     = st_end && pulse_ok && !locked && (low_cnt >= LOW_LIM);

    // Delayed strobe copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) strobe_d <= 1'b0;
        else        strobe_d <= strobe;
    end

    // Count strobe samples, saturating one past the minimum.
    always_ff @(posedge clk) begin
        if (!rst_n || !strobe)  low_cnt <= '0;
        else if (low_cnt <= LOW_LIM) low_cnt <= low_cnt + 1'b1;
    end

    // Count idle samples since the last strobe, saturating at the minimum.
    always_ff @(posedge clk) begin
        if (!rst_n)              high_cnt <= HIGH_LIM;
        else if (strobe)         high_cnt <= '0;
        else if (high_cnt < HIGH_LIM) high_cnt <= high_cnt + 1'b1;
    end

    // Track whether the current strobe is still eligible.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pulse_ok <= 1'b0;
        end else if (st_begin) begin
            pulse_ok <= (high_cnt >= HIGH_LIM) && oe_high && !locked;
        end else if (strobe) begin
            pulse_ok <= pulse_ok && oe_high && !locked;
        end
    end

    // Address on the first strobe sample, data on every strobe sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_cap <= '0;
            data_cap <= '0;
        end else begin
            if (st_begin) addr_cap <= addr_s;
            if (strobe)   data_cap <= data_s;
        end
    end

    // Publish an accepted write for exactly one clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_valid <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_valid <= fire;
            if (fire) begin
                wr_addr <= addr_cap;
                wr_data <= data_cap;
            end
        end
    end
endmodule

// File: rtl/pfw_read_ctrl.sv
`timescale 1ns/1ps
// Module: pfw_read_ctrl
// Derives the registered read-active and output-driver enables from the
// synchronised pins. Chip-select high forces both off.
module pfw_read_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n_s,
    input  logic oe_n_s,
    input  logic we_n_s,
    output logic rd_active,
    output logic dout_en
);
    // Register the read decode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_active <= 1'b0;
            dout_en   <= 1'b0;
        end else begin
            rd_active <= !ce_n_s && !oe_n_s;
            dout_en   <= !ce_n_s && !oe_n_s && we_n_s;
        end
    end
endmodule

// File: rtl/pfw_frontend.sv
`timescale 1ns/1ps
// Module: pfw_frontend (top)
// Flash bus write front end: synchronises the pins, times the startup
// lockout, qualifies writes and drives the read enables.
// Assumes the address and data buses are stable around the strobe edges.
module pfw_frontend #(
    parameter int AW          = 18,
    parameter int DW          = 8,
    parameter int MIN_LOW     = 2,
    parameter int MIN_HIGH    = 5,
    parameter int STARTUP_CYC = 250000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_good,
    input  logic          ce_n_pin,
    input  logic          oe_n_pin,
    input  logic          we_n_pin,
    input  logic [AW-1:0] addr_pin,
    input  logic [DW-1:0] data_pin,
    output logic          wr_valid,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          rd_active,
    output logic          dout_en
);
    import pfw_pkg::*;

    localparam int BW = AW + DW;

    pin_ctrl_t     ctrl_raw;
    pin_ctrl_t     ctrl_s;
    logic [BW-1:0] bus_s;
    logic          locked;
    logic          strobe;

    assign ctrl_raw = '{ce_n: ce_n_pin, oe_n: oe_n_pin, we_n: we_n_pin, pwr_ok: pwr_good};

    pfw_sync #(.W(CTRL_W), .RST_VAL(CTRL_IDLE)) u_ctrl_sync (
        .clk(clk), .rst_n(rst_n), .d_in(ctrl_raw), .d_out(ctrl_s)
    );

    pfw_sync #(.W(BW), .RST_VAL({BW{1'b0}})) u_bus_align (
        .clk(clk), .rst_n(rst_n), .d_in({addr_pin, data_pin}), .d_out(bus_s)
    );

    pfw_lockout #(.STARTUP_CYC(STARTUP_CYC)) u_lock (
        .clk(clk), .rst_n(rst_n), .pwr_ok_s(ctrl_s.pwr_ok), .locked(locked)
    );

    assign strobe = !ctrl_s.ce_n && !ctrl_s.we_n;

    pfw_write_qual #(.AW(AW), .DW(DW), .MIN_LOW(MIN_LOW), .MIN_HIGH(MIN_HIGH)) u_wq (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .oe_high(ctrl_s.oe_n),
        .locked(locked), .addr_s(bus_s[BW-1:DW]), .data_s(bus_s[DW-1:0]),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data)
    );

    pfw_read_ctrl u_rd (
        .clk(clk), .rst_n(rst_n), .ce_n_s(ctrl_s.ce_n), .oe_n_s(ctrl_s.oe_n),
        .we_n_s(ctrl_s.we_n), .rd_active(rd_active), .dout_en(dout_en)
    );
endmodule

// File: rtl/pfw_frontend_chk.sv
`timescale 1ns/1ps
// Module: pfw_frontend_chk
// Port-level properties of the front end, bound to the top module.
module pfw_frontend_chk #(
    parameter int STARTUP_CYC = 250000
) (
    input logic clk,
    input logic rst_n,
    input logic pwr_good,
    input logic ce_n_pin,
    input logic oe_n_pin,
    input logic we_n_pin,
    input logic wr_valid,
    input logic rd_active,
    input logic dout_en
);
    logic [31:0] good_cnt;

    // Count raw good-power clocks for the lockout window.
    always_ff @(posedge clk) begin
        if (!rst_n || !pwr_good)              good_cnt <= '0;
        else if (good_cnt < 32'(STARTUP_CYC) + 32'd4) good_cnt <= good_cnt + 32'd1;
    end

    p_valid_one_cycle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |=> !wr_valid);

    p_lockout_blocks_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid |-> (good_cnt >= 32'(STARTUP_CYC)));

    p_standby_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ce_n_pin, 3) |-> (!rd_active && !dout_en));

    p_read_needs_both_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd_active |-> (!$past(ce_n_pin, 3) && !$past(oe_n_pin, 3)));

    p_drive_needs_we_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dout_en |-> ($past(we_n_pin, 3) && rd_active));
endmodule

bind pfw_frontend pfw_frontend_chk #(.STARTUP_CYC(STARTUP_CYC)) u_chk (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .ce_n_pin(ce_n_pin),
    .oe_n_pin(oe_n_pin), .we_n_pin(we_n_pin), .wr_valid(wr_valid),
    .rd_active(rd_active), .dout_en(dout_en)
);

// File: tb/pfw_frontend_tb.sv
`timescale 1ns/1ps
module pfw_frontend_tb;
    localparam int AW = 8, DW = 8, MIN_LOW = 3, MIN_HIGH = 4, STARTUP = 40;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_good = 1'b0;
    logic ce_n = 1'b0, oe_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] data = '0;
    logic wr_valid, rd_active, dout_en;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    int checks = 0, errors = 0;
    int vcount = 0, wide = 0;
    logic [AW-1:0] last_a = '0;
    logic [DW-1:0] last_d = '0;
    logic prev_v = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pfw_frontend #(.AW(AW), .DW(DW), .MIN_LOW(MIN_LOW), .MIN_HIGH(MIN_HIGH),
                   .STARTUP_CYC(STARTUP)) u_dut (
        .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .ce_n_pin(ce_n),
        .oe_n_pin(oe_n), .we_n_pin(we_n), .addr_pin(addr), .data_pin(data),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_active(rd_active), .dout_en(dout_en)
    );

    // Monitor write events away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (wr_valid) begin
                vcount++;
                last_a = wr_addr;
                last_d = wr_data;
                if (prev_v) wide++;
            end
            prev_v = wr_valid;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Strobe via write-strobe while chip-select is held low.
    task automatic we_pulse(input logic [AW-1:0] a, input logic [DW-1:0] d, input int len);
        @(negedge clk); addr = a; data = d; we_n = 1'b0;
        idle(len);
        we_n = 1'b1;
        idle(10);
    endtask

    initial begin
        int base;
        idle(3);
        rst_n = 1'b1;
        idle(1);
        chk(!wr_valid && !rd_active && !dout_en, "R1 reset outputs",
            {wr_valid, rd_active, dout_en}, 0);

        // R6: power not good, then early after rise, then after lockout.
        base = vcount;
        we_pulse(8'h10, 8'h20, 5);
        chk(vcount == base, "R6 write while power low", vcount - base, 0);
        pwr_good = 1'b1;
        we_pulse(8'h11, 8'h21, 5);
        chk(vcount == base, "R6 write inside startup window", vcount - base, 0);
        idle(STARTUP + 10);
        we_pulse(8'h12, 8'h22, 5);
        chk(vcount == base + 1, "R6 write after startup window", vcount - base, 1);

        // R2/R3: sweep strobe length around the minimum.
        for (int len = 1; len <= 6; len++) begin
            base = vcount;
            we_pulse(8'(8'h40 + len), 8'(8'h80 + len), len);
            if (len >= MIN_LOW) begin
                chk(vcount == base + 1, "R2 long strobe accepted", vcount - base, 1);
                chk(last_a == 8'(8'h40 + len) && last_d == 8'(8'h80 + len),
                    "R2 address and data", {last_a, last_d}, {8'(8'h40 + len), 8'(8'h80 + len)});
            end else begin
                chk(vcount == base, "R3 short strobe rejected", vcount - base, 0);
            end
        end
        chk(wide == 0, "R2 event one clock wide", wide, 0);

        // R7/R8: bus changes mid strobe.
        base = vcount;
        @(negedge clk); addr = 8'h11; data = 8'h22; we_n = 1'b0;
        idle(2); addr = 8'h33; data = 8'h44;
        idle(3); we_n = 1'b1;
        idle(10);
        chk(vcount == base + 1 && last_a == 8'h11, "R7 address from first sample", last_a, 8'h11);
        chk(last_d == 8'h44, "R8 data from last sample", last_d, 8'h44);

        // R7/R8: chip-select falls late and rises early.
        base = vcount;
        @(negedge clk); ce_n = 1'b1;
        idle(3); we_n = 1'b0; addr = 8'h55; data = 8'h66;
        idle(3); addr = 8'h77; ce_n = 1'b0;
        idle(4); ce_n = 1'b1; data = 8'h99;
        idle(3); we_n = 1'b1;
        idle(3); ce_n = 1'b0;
        idle(10);
        chk(vcount == base + 1 && last_a == 8'h77, "R7 address at later fall", last_a, 8'h77);
        chk(last_d == 8'h66, "R8 data before earlier rise", last_d, 8'h66);

        // R4: output gate low for whole strobe, then only mid strobe.
        base = vcount;
        @(negedge clk); oe_n = 1'b0;
        we_pulse(8'h01, 8'h02, 5);
        oe_n = 1'b1;
        idle(5);
        chk(vcount == base, "R4 gate low whole strobe", vcount - base, 0);
        @(negedge clk); we_n = 1'b0;
        idle(2); oe_n = 1'b0;
        idle(3); we_n = 1'b1; oe_n = 1'b1;
        idle(10);
        chk(vcount == base, "R4 gate low mid strobe", vcount - base, 0);

        // R5: chip-select high, strobe pulsed.
        base = vcount;
        @(negedge clk); ce_n = 1'b1;
        we_pulse(8'h03, 8'h04, 6);
        ce_n = 1'b0;
        idle(5);
        chk(vcount == base, "R5 no write in standby", vcount - base, 0);

        // R9: gap between two strobes swept around the minimum.
        for (int h = 1; h <= 6; h++) begin
            base = vcount;
            @(negedge clk); addr = 8'hA0; data = 8'hB0; we_n = 1'b0;
            idle(4); we_n = 1'b1;
            idle(h); addr = 8'(8'hC0 + h); data = 8'(8'hD0 + h); we_n = 1'b0;
            idle(4); we_n = 1'b1;
            idle(10);
            if (h >= MIN_HIGH) begin
                chk(vcount == base + 2 && last_a == 8'(8'hC0 + h), "R9 gap long enough",
                    vcount - base, 2);
            end else begin
                chk(vcount == base + 1 && last_a == 8'hA0, "R9 early strobe ignored",
                    vcount - base, 1);
            end
        end

        // R10/R5: every pin combination for the read enables.
        for (int i = 0; i < 8; i++) begin
            logic c, o, w;
            c = i[2]; o = i[1]; w = i[0];
            @(negedge clk); ce_n = c; oe_n = o; we_n = w;
            idle(4);
            chk(rd_active == (!c && !o), c ? "R5 standby read off" : "R10 read active",
                rd_active, (!c && !o));
            chk(dout_en == (!c && !o && w), "R10 output enable", dout_en, (!c && !o && w));
        end
        @(negedge clk); ce_n = 1'b0; oe_n = 1'b1; we_n = 1'b1;
        idle(10);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule